// File: doc/BRIEF.md
# Single-Wire Bus Slave Reset and Presence Responder

This block sits on the slave side of an open-drain single-wire bus. It measures every low period on the line in microseconds. A low period long enough to be a master reset makes the block answer once the line is released: it waits a short, fixed delay, then pulls the line low for a presence pulse. The block has two speeds, regular and overdrive. Each speed has its own reset threshold and its own presence timing. The length of a reset decides whether overdrive is kept or left.

Higher logic asks for overdrive with a one-cycle request. The block reports the speed it is in and gives a one-cycle strobe each time a reset is accepted, so that command decoding can restart. The bus carries no data stream through this block, so it has no valid/ready handshake. Every pin is a plain level or a strobe. The bus input is synchronised inside the block. A microsecond tick comes from a clock divider set by `CLK_PER_US`. All timing below is in ticks of that divider.

Top module: `ow_reset_responder`

## Requirements
- R1: After the synchronous reset, `pd_en`, `rst_det` and `od_mode` are all 0.
- R2: At regular speed (`od_mode`=0), a low of at least 480 us followed by a release is a reset. `pd_en` rises 30 us after the release, plus at most a few clocks of synchroniser delay. It stays high for 120 us, within two clocks.
- R3: At regular speed, a low shorter than 480 us (478 us or less) gives no presence pulse and no strobe.
- R4: A one-cycle `ovd_req` makes `od_mode` equal 1 on the next clock.
- R5: At overdrive speed, a low from 48 us to 80 us is a reset. The presence pulse starts 3 us after the release and lasts 12 us, and `od_mode` stays 1.
- R6: At overdrive speed, a low shorter than 48 us (46 us or less) gives no presence pulse and leaves `od_mode` at 1.
- R7: A reset low of 480 us or more clears `od_mode` to 0, in either speed. The presence pulse that follows uses regular timing.
- R8: At overdrive speed, a reset low longer than 80 us but shorter than 480 us keeps `od_mode` at 1 and gives overdrive presence timing.
- R9: `rst_det` is high for exactly one clock, in the same cycle in which `pd_en` rises.
- R10: A low that begins while `pd_en` is high is never measured as a reset. This holds even if the master keeps the line low after the presence pulse ends. The release that follows gives no presence pulse.
- R11: A falling edge during the delay before presence cancels the pending presence. The new low is measured on its own merits, and a short one gives no presence pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_i | input | 1 | Sampled level of the bus line (1 = released) |
| ovd_req | input | 1 | One-cycle request to enter overdrive speed |
| pd_en | output | 1 | Pull-down enable: 1 drives the line low (presence pulse) |
| rst_det | output | 1 | One-cycle strobe: a reset was accepted and presence starts |
| od_mode | output | 1 | Current speed: 1 = overdrive, 0 = regular |

## Verification
The assertions check the following on every cycle:
- The strobe is a single cycle and lines up with the rising edge of the pull-down.
- A presence pulse never runs past the regular width.
- Overdrive is entered only after a request.
- Overdrive is left only after a raw low that reaches the long reset length.

Only the bench scenarios can show the rest:
- Which low lengths count as a reset at each speed.
- The delay and width of presence at each speed.
- The boundary lengths of 478/482 us and 46/50 us.
- That overdrive is kept across mid-length resets.
- That a low started during presence or during the delay is not taken as a reset.

// File: rtl/ow_resp_pkg.sv
package ow_resp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_WAIT,
    ST_PRES,
    ST_SETTLE
  } ow_state_e;
endpackage

// File: rtl/ow_sync.sv
module ow_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic fell,
  output logic rose
);
  logic [STAGES-1:0] q;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      q    <= '1;
      prev <= 1'b1;
    end else begin
      q    <= {q[STAGES-2:0], din};
      prev <= q[STAGES-1];
    end
  end

  assign level = q[STAGES-1];
  assign fell  = prev & ~level;
  assign rose  = ~prev & level;
endmodule

// File: rtl/ow_us_timer.sv
module ow_us_timer #(
  parameter int CLK_PER_US = 50,
  parameter int CNT_W      = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  output logic [CNT_W-1:0] us_cnt
);
  localparam int DIV_W = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_PER_US - 1);

  logic [DIV_W-1:0] div;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      div    <= '0;
      us_cnt <= '0;
    end else if (div == DIV_LAST) begin
      div <= '0;
      if (us_cnt != '1) us_cnt <= us_cnt + 1'b1;
    end else begin
      div <= div + 1'b1;
    end
  end
endmodule

// File: rtl/ow_ctrl.sv
module ow_ctrl
  import ow_resp_pkg::*;
#(
  parameter int CNT_W       = 10,
  parameter int RST_REG_US  = 480,
  parameter int RST_OD_US   = 48,
  parameter int WAIT_REG_US = 30,
  parameter int PRES_REG_US = 120,
  parameter int WAIT_OD_US  = 3,
  parameter int PRES_OD_US  = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             level,
  input  logic             fell,
  input  logic             rose,
  input  logic [CNT_W-1:0] us_cnt,
  input  logic             ovd_req,
  output logic             clr,
  output logic             pd_en,
  output logic             rst_det,
  output logic             od_mode
);
  localparam logic [CNT_W-1:0] T_RST_REG  = CNT_W'(RST_REG_US);
  localparam logic [CNT_W-1:0] T_RST_OD   = CNT_W'(RST_OD_US);
  localparam logic [CNT_W-1:0] T_WAIT_REG = CNT_W'(WAIT_REG_US);
  localparam logic [CNT_W-1:0] T_PRES_REG = CNT_W'(PRES_REG_US);
  localparam logic [CNT_W-1:0] T_WAIT_OD  = CNT_W'(WAIT_OD_US);
  localparam logic [CNT_W-1:0] T_PRES_OD  = CNT_W'(PRES_OD_US);

  ow_state_e        st, nxt;
  logic             od_nxt, det_nxt;
  logic [CNT_W-1:0] thr, wait_t, pres_t;

  assign thr    = od_mode ? T_RST_OD  : T_RST_REG;
  assign wait_t = od_mode ? T_WAIT_OD : T_WAIT_REG;
  assign pres_t = od_mode ? T_PRES_OD : T_PRES_REG;

  always_comb begin
    nxt     = st;
    clr     = 1'b0;
    det_nxt = 1'b0;
    od_nxt  = od_mode | ovd_req;
    case (st)
      ST_IDLE: if (fell) begin
        nxt = ST_LOW;
        clr = 1'b1;
      end
      ST_LOW: if (rose) begin
        if (us_cnt >= thr) begin
          nxt = ST_WAIT;
          clr = 1'b1;
          if (us_cnt >= T_RST_REG) od_nxt = 1'b0;
        end else begin
          nxt = ST_IDLE;
        end
      end
      ST_WAIT: begin
        if (fell) begin
          nxt = ST_LOW;
          clr = 1'b1;
        end else if (us_cnt >= wait_t) begin
          nxt     = ST_PRES;
          clr     = 1'b1;
          det_nxt = 1'b1;
        end
      end
      ST_PRES:   if (us_cnt >= pres_t) nxt = ST_SETTLE;
      ST_SETTLE: if (level) nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      od_mode <= 1'b0;
      pd_en   <= 1'b0;
      rst_det <= 1'b0;
    end else begin
      st      <= nxt;
      od_mode <= od_nxt;
      pd_en   <= (nxt == ST_PRES);
      rst_det <= det_nxt;
    end
  end
endmodule

// File: rtl/ow_reset_responder.sv
module ow_reset_responder #(
  parameter int CLK_PER_US  = 50,
  parameter int SYNC_STAGES = 2,
  parameter int RST_REG_US  = 480,
  parameter int RST_OD_US   = 48,
  parameter int WAIT_REG_US = 30,
  parameter int PRES_REG_US = 120,
  parameter int WAIT_OD_US  = 3,
  parameter int PRES_OD_US  = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_i,
  input  logic ovd_req,
  output logic pd_en,
  output logic rst_det,
  output logic od_mode
);
  localparam int CNT_W = $clog2(RST_REG_US + 1) + 1;

  logic             level, fell, rose, clr;
  logic [CNT_W-1:0] us_cnt;

  ow_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(bus_i),
    .level(level), .fell(fell), .rose(rose)
  );

  ow_us_timer #(.CLK_PER_US(CLK_PER_US), .CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst(rst), .clr(clr), .us_cnt(us_cnt)
  );

  ow_ctrl #(
    .CNT_W(CNT_W), .RST_REG_US(RST_REG_US), .RST_OD_US(RST_OD_US),
    .WAIT_REG_US(WAIT_REG_US), .PRES_REG_US(PRES_REG_US),
    .WAIT_OD_US(WAIT_OD_US), .PRES_OD_US(PRES_OD_US)
  ) u_ctrl (
    .clk(clk), .rst(rst), .level(level), .fell(fell), .rose(rose),
    .us_cnt(us_cnt), .ovd_req(ovd_req), .clr(clr),
    .pd_en(pd_en), .rst_det(rst_det), .od_mode(od_mode)
  );
endmodule

// File: rtl/ow_resp_checker.sv
module ow_resp_checker #(
  parameter int CLK_PER_US  = 50,
  parameter int RST_REG_US  = 480,
  parameter int PRES_REG_US = 120
) (
  input logic clk,
  input logic rst,
  input logic bus_i,
  input logic ovd_req,
  input logic pd_en,
  input logic rst_det,
  input logic od_mode
);
  localparam int PD_MAX  = PRES_REG_US * CLK_PER_US + 2;
  localparam int LONG_LO = (RST_REG_US - 1) * CLK_PER_US;

  int low_run, last_run, pd_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_run  <= 0;
      last_run <= 0;
      pd_run   <= 0;
    end else begin
      if (!bus_i) low_run <= (low_run < 32'h3fff_ffff) ? low_run + 1 : low_run;
      else begin
        if (low_run != 0) last_run <= low_run;
        low_run <= 0;
      end
      pd_run <= pd_en ? pd_run + 1 : 0;
    end
  end

  p_strobe_single_r9: assert property (@(posedge clk) disable iff (rst)
    rst_det |=> !rst_det);
  p_strobe_at_pd_rise_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(pd_en) |-> rst_det);
  p_strobe_with_pd_r9: assert property (@(posedge clk) disable iff (rst)
    rst_det |-> pd_en);
  p_od_enter_needs_req_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(od_mode) |-> $past(ovd_req));
  p_od_exit_long_low_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(od_mode) |-> (last_run >= LONG_LO));
  p_pd_width_bound_r2: assert property (@(posedge clk) disable iff (rst)
    pd_en |-> (pd_run < PD_MAX));
endmodule

bind ow_reset_responder ow_resp_checker #(
  .CLK_PER_US(CLK_PER_US), .RST_REG_US(RST_REG_US), .PRES_REG_US(PRES_REG_US)
) u_chk (
  .clk(clk), .rst(rst), .bus_i(bus_i), .ovd_req(ovd_req),
  .pd_en(pd_en), .rst_det(rst_det), .od_mode(od_mode)
);

// File: tb/sim_ow_reset_responder.sv
module sim_ow_reset_responder;
  localparam int CPU = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_low = 1'b0;
  logic ovd_req = 1'b0;
  logic bus_i, pd_en, rst_det, od_mode;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;
  bit  exp_od = 1'b0;

  always #10 clk = ~clk;
  assign bus_i = ~(m_low | pd_en);

  ow_reset_responder #(.CLK_PER_US(CPU)) u0 (
    .clk(clk), .rst(rst), .bus_i(bus_i), .ovd_req(ovd_req),
    .pd_en(pd_en), .rst_det(rst_det), .od_mode(od_mode)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit is_reset(input bit od, input int len);
    return len >= (od ? 48 : 480);
  endfunction

  function automatic bit od_after(input bit od, input int len);
    return (is_reset(od, len) && len >= 480) ? 1'b0 : od;
  endfunction

  task automatic idle_us(input int us);
    repeat (us * CPU) @(negedge clk);
  endtask

  task automatic req_od();
    ovd_req = 1'b1;
    @(negedge clk);
    ovd_req = 1'b0;
    exp_od = 1'b1;
    chk(od_mode == 1'b1, "R4", od_mode, 1);
  endtask

  // Drive a low of len us, release, and watch for a presence pulse.
  task automatic low_pulse(input int len, output bit got, output int dly,
                           output int wid, output int strobes, output bit aligned);
    m_low = 1'b1;
    repeat (len * CPU) @(negedge clk);
    m_low = 1'b0;
    got = 0; dly = 0; wid = 0; strobes = 0; aligned = 0;
    for (int c = 1; c <= 190 * CPU; c++) begin
      @(negedge clk);
      if (rst_det) strobes++;
      if (pd_en) begin
        if (!got) begin
          got = 1; dly = c; aligned = rst_det;
        end
        wid++;
      end else if (got) break;
    end
  endtask

  // Full scenario: expected values from the requirement rules.
  task automatic scenario(input int len, input string req);
    bit got, aligned, e_rst, new_od;
    int dly, wid, strobes, w, p;
    e_rst  = is_reset(exp_od, len);
    new_od = od_after(exp_od, len);
    w = new_od ? 3 : 30;
    p = new_od ? 12 : 120;
    low_pulse(len, got, dly, wid, strobes, aligned);
    chk(got == e_rst, req, got, e_rst);
    if (e_rst && got) begin
      chk(dly >= w * CPU && dly <= w * CPU + 8, req, dly, w * CPU);
      chk(wid >= p * CPU - 2 && wid <= p * CPU + 2, req, wid, p * CPU);
      chk(strobes == 1 && aligned, "R9", strobes, 1);
    end else begin
      chk(strobes == 0, req, strobes, 0);
    end
    exp_od = new_od;
    idle_us(10);
    chk(od_mode == exp_od, req, od_mode, exp_od);
  endtask

  initial begin
    void'($urandom(32'h00C0FFEE));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(pd_en == 0, "R1", pd_en, 0);
    chk(rst_det == 0, "R1", rst_det, 0);
    chk(od_mode == 0, "R1", od_mode, 0);
    idle_us(5);

    scenario(500, "R2");
    scenario(478, "R3");
    scenario(482, "R2");
    req_od();
    scenario(60, "R5");
    scenario(46, "R6");
    scenario(50, "R5");
    scenario(200, "R8");
    scenario(500, "R7");
    req_od();
    scenario(482, "R7");

    // R10: master starts a long low during the presence pulse
    begin
      int seen = 0;
      m_low = 1'b1; idle_us(500); m_low = 1'b0;
      idle_us(40);
      chk(pd_en == 1, "R10", pd_en, 1);
      m_low = 1'b1; idle_us(600); m_low = 1'b0;
      for (int c = 0; c < 200 * CPU; c++) begin
        @(negedge clk);
        if (pd_en || rst_det) seen++;
      end
      chk(seen == 0, "R10", seen, 0);
    end

    // R11: short low during the delay before presence
    begin
      int seen = 0;
      m_low = 1'b1; idle_us(500); m_low = 1'b0;
      idle_us(10);
      m_low = 1'b1; idle_us(5); m_low = 1'b0;
      for (int c = 0; c < 200 * CPU; c++) begin
        @(negedge clk);
        if (pd_en || rst_det) seen++;
      end
      chk(seen == 0, "R11", seen, 0);
    end

    // Constrained random mix
    for (int i = 0; i < 16; i++) begin
      int len;
      if ($urandom % 3 == 0) req_od();
      len = 1 + ($urandom % 600);
      if ((len >= 46 && len <= 50) || (len >= 478 && len <= 482)) len += 5;
      scenario(len, exp_od ? "R5" : "R2");
    end

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule